// File: doc/BRIEF.md
# Memory Error Capture and Event Counting

This block is the control and status side of a memory error-correction unit. An external codec reports check results from three paths: a data port, a program port and a DMA path. Any of them may report in the same cycle. The block gates those reports with a global operating mode and with one enable bit per page of the protected range. It keeps exactly one captured error record and raises one of two level exceptions, one for correctable and one for uncorrectable errors. It also counts every qualifying correctable and uncorrectable event in two saturating counters that clear when read.

Software controls the block through write-1 command strobes and two page-enable register writes. The codec asks whether an address is currently protected through a combinational probe, which it uses to decide whether to generate or check code bits. All results except the probe are registered and appear one cycle after the edge that samples the stimulus.

Top module: `edc_err_capture`

## Requirements
- R1: The mode resets to off and is shown on `mode_o` as 0 = off, 1 = on, 2 = hold (suspended). A `cmd_we` cycle with exactly one of `cmd_on`, `cmd_off` or `cmd_hold` set moves to that mode. With none of them set, the mode stays as it is.
- R2: A `cmd_we` cycle with two or more of `cmd_on`, `cmd_off` and `cmd_hold` set moves the mode to off.
- R3: The 64 page-enable bits reset to 0. `pen_we[k]` loads `pen_wdata` into bits 32k+31..32k. The page of an address is `addr[20:15]`. `probe_chk` is 1 only when the mode is on and the page of `probe_addr` is enabled.
- R4: A report counts and is captured only if the mode is on and the page of its address is enabled. Otherwise it changes neither the record nor the counters.
- R5: When the record is empty, a qualifying report is captured. `rec_src` bit 0 = data, 1 = program, 2 = DMA. The record also holds the address bits 31:5, the RAM flag (1 = RAM), the bit position, and the way, which is forced to 0 when the RAM flag is 1.
- R6: While a record is held, later reports leave it unchanged, except as R7 allows.
- R7: An uncorrectable report overwrites a held correctable record.
- R8: Among reports in the same cycle, uncorrectable beats correctable. Within the same class, data beats program and program beats DMA.
- R9: A `cmd_we` cycle with `cmd_clr` bit i set empties the record (all fields 0) if `rec_src` bit i is set. A clear bit for another source has no effect. A qualifying report in the same cycle as the clear is captured into the emptied record.
- R10: `exc_corr` is high while a correctable record is held. `exc_unc` is high while an uncorrectable record is held.
- R11: `cnt_corr` and `cnt_unc` add every qualifying event of their class, including simultaneous events and events that arrive while a record is held.
- R12: The counters saturate at 255.
- R13: A read strobe makes the counter's next value equal to the number of events of that cycle (0 when there are none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_on | input | 1 | Write-1: switch mode to on |
| cmd_off | input | 1 | Write-1: switch mode to off |
| cmd_hold | input | 1 | Write-1: switch mode to hold |
| cmd_clr | input | 3 | Write-1 record clear per source (0 data, 1 program, 2 DMA) |
| pen_we | input | 2 | Page-enable register write strobes |
| pen_wdata | input | 32 | Page-enable write data |
| probe_addr | input | 32 | Address whose protection is queried |
| probe_chk | output | 1 | Address is protected now |
| mode_o | output | 2 | Current mode |
| rpt_vld | input | 3 | Error report valid per source |
| rpt_unc | input | 3 | Report is uncorrectable |
| rpt_addr | input | 96 | Report address, 32 bits per source |
| rpt_way | input | 6 | Cache way, 2 bits per source |
| rpt_ram | input | 3 | Report hit RAM (1) or cache (0) |
| rpt_bit | input | 24 | Failing bit position, 8 bits per source |
| cnt_rd_corr | input | 1 | Read strobe of correctable counter |
| cnt_rd_unc | input | 1 | Read strobe of uncorrectable counter |
| rec_src | output | 3 | One-hot source of the held record |
| rec_unc | output | 1 | Held record is uncorrectable |
| rec_addr | output | 27 | Captured address bits 31:5 |
| rec_way | output | 2 | Captured way |
| rec_ram | output | 1 | Captured RAM flag |
| rec_bit | output | 8 | Captured bit position |
| exc_corr | output | 1 | Correctable exception |
| exc_unc | output | 1 | Uncorrectable exception |
| cnt_corr | output | 8 | Correctable event count |
| cnt_unc | output | 8 | Uncorrectable event count |

## Verification
Mode, page enables, record, exceptions and counters are all registers, so each of them shows the effect of a stimulus one cycle after the edge that samples it. The probe output is combinational over those registers and the probe address. The bench drives inputs 1 ns after a rising edge, advances its own model at the next edge, and compares every output 1 ns after that edge. No comparison can fall on an edge or a cycle early.

// File: rtl/edc_cap_pkg.sv
package edc_cap_pkg;
   typedef enum logic [1:0] {
      MODE_OFF  = 2'd0,
      MODE_ON   = 2'd1,
      MODE_HOLD = 2'd2
   } edc_mode_e;

   localparam int unsigned SRC_DATA = 0;
   localparam int unsigned SRC_PROG = 1;
   localparam int unsigned SRC_DMA  = 2;
   localparam int unsigned NUM_SRC  = 3;
endpackage

// File: rtl/edc_ctl_regs.sv
module edc_ctl_regs
   import edc_cap_pkg::*;
#(
   parameter int unsigned PAGE_BITS = 6,
   parameter int unsigned PEN_W     = 32,
   localparam int unsigned NUM_PAGES = 1 << PAGE_BITS,
   localparam int unsigned NREG      = NUM_PAGES / PEN_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_we,
   input  logic                 cmd_on,
   input  logic                 cmd_off,
   input  logic                 cmd_hold,
   input  logic [NREG-1:0]      pen_we,
   input  logic [PEN_W-1:0]     pen_wdata,
   output edc_mode_e            mode_o,
   output logic [NUM_PAGES-1:0] pen_o
);
   generate
      if (NUM_PAGES % PEN_W != 0) begin : g_bad_split
         $error("page count must be a multiple of the register width");
      end
   endgenerate

   edc_mode_e            mode_q, mode_nx;
   logic [1:0]           n_cmd;
   logic [NUM_PAGES-1:0] pen_q;

   always_comb begin
      n_cmd   = {1'b0, cmd_on} + {1'b0, cmd_off} + {1'b0, cmd_hold};
      mode_nx = mode_q;
      if (cmd_we) begin
         if (n_cmd > 2'd1)  mode_nx = MODE_OFF;
         else if (cmd_on)   mode_nx = MODE_ON;
         else if (cmd_off)  mode_nx = MODE_OFF;
         else if (cmd_hold) mode_nx = MODE_HOLD;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_OFF;
         pen_q  <= '0;
      end else begin
         mode_q <= mode_nx;
         for (int k = 0; k < NREG; k++) begin
            if (pen_we[k]) pen_q[k*PEN_W +: PEN_W] <= pen_wdata;
         end
      end
   end

   assign mode_o = mode_q;
   assign pen_o  = pen_q;
endmodule

// File: rtl/edc_err_pick.sv
module edc_err_pick #(
   parameter int unsigned NUM_SRC = 3,
   localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] hit,
   input  logic [NUM_SRC-1:0] unc,
   output logic               win_vld,
   output logic [IDX_W-1:0]   win_idx,
   output logic               win_unc
);
   // lower index wins within a class; the uncorrectable pass runs last
   always_comb begin
      win_vld = 1'b0;
      win_idx = '0;
      win_unc = 1'b0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (hit[i] && !unc[i]) begin
            win_vld = 1'b1;
            win_idx = IDX_W'(i);
         end
      end
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (hit[i] && unc[i]) begin
            win_vld = 1'b1;
            win_idx = IDX_W'(i);
            win_unc = 1'b1;
         end
      end
   end
endmodule

// File: rtl/edc_evt_cnt.sv
module edc_evt_cnt #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned INC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] cnt_o
);
   generate
      if (INC_W >= CNT_W) begin : g_bad_inc
         $error("increment width must be below the counter width");
      end
   endgenerate

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q, base;
   logic [CNT_W:0]   sum;

   always_comb begin
      base = rd ? '0 : cnt_q;
      sum  = {1'b0, base} + (CNT_W + 1)'(inc);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (sum[CNT_W]) cnt_q <= CNT_MAX;
      else               cnt_q <= sum[CNT_W-1:0];
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/edc_err_capture.sv
module edc_err_capture
   import edc_cap_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PAGE_BITS = 6,
   parameter int unsigned PAGE_LSB  = 15,
   parameter int unsigned PEN_W     = 32,
   parameter int unsigned CAP_LSB   = 5,
   parameter int unsigned WAY_W     = 2,
   parameter int unsigned BIT_W     = 8,
   parameter int unsigned CNT_W     = 8,
   localparam int unsigned NUM_PAGES = 1 << PAGE_BITS,
   localparam int unsigned NREG      = NUM_PAGES / PEN_W,
   localparam int unsigned CAP_W     = ADDR_W - CAP_LSB,
   localparam int unsigned IDX_W     = $clog2(NUM_SRC),
   localparam int unsigned INC_W     = $clog2(NUM_SRC + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_we,
   input  logic                       cmd_on,
   input  logic                       cmd_off,
   input  logic                       cmd_hold,
   input  logic [NUM_SRC-1:0]         cmd_clr,
   input  logic [NREG-1:0]            pen_we,
   input  logic [PEN_W-1:0]           pen_wdata,
   input  logic [ADDR_W-1:0]          probe_addr,
   output logic                       probe_chk,
   output logic [1:0]                 mode_o,
   input  logic [NUM_SRC-1:0]         rpt_vld,
   input  logic [NUM_SRC-1:0]         rpt_unc,
   input  logic [NUM_SRC*ADDR_W-1:0]  rpt_addr,
   input  logic [NUM_SRC*WAY_W-1:0]   rpt_way,
   input  logic [NUM_SRC-1:0]         rpt_ram,
   input  logic [NUM_SRC*BIT_W-1:0]   rpt_bit,
   input  logic                       cnt_rd_corr,
   input  logic                       cnt_rd_unc,
   output logic [NUM_SRC-1:0]         rec_src,
   output logic                       rec_unc,
   output logic [CAP_W-1:0]           rec_addr,
   output logic [WAY_W-1:0]           rec_way,
   output logic                       rec_ram,
   output logic [BIT_W-1:0]           rec_bit,
   output logic                       exc_corr,
   output logic                       exc_unc,
   output logic [CNT_W-1:0]           cnt_corr,
   output logic [CNT_W-1:0]           cnt_unc
);
   generate
      if (PAGE_LSB + PAGE_BITS > ADDR_W) begin : g_bad_page
         $error("page slice exceeds the address width");
      end
      if (CAP_LSB >= ADDR_W) begin : g_bad_cap
         $error("captured address slice is empty");
      end
   endgenerate

   edc_mode_e            mode;
   logic [NUM_PAGES-1:0] pen;
   logic [NUM_SRC-1:0]   hit;
   logic                 win_vld, win_unc;
   logic [IDX_W-1:0]     win_idx;
   logic                 unused_addr;

   assign unused_addr = ^{probe_addr, rpt_addr};

   edc_ctl_regs #(.PAGE_BITS(PAGE_BITS), .PEN_W(PEN_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_on(cmd_on),
      .cmd_off(cmd_off), .cmd_hold(cmd_hold), .pen_we(pen_we),
      .pen_wdata(pen_wdata), .mode_o(mode), .pen_o(pen)
   );

   assign mode_o    = mode;
   assign probe_chk = (mode == MODE_ON) && pen[probe_addr[PAGE_LSB +: PAGE_BITS]];

   // a report qualifies only in on mode and inside an enabled page
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_qual
         assign hit[i] = rpt_vld[i] && (mode == MODE_ON) &&
                         pen[rpt_addr[i*ADDR_W + PAGE_LSB +: PAGE_BITS]];
      end
   endgenerate

   edc_err_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .hit(hit), .unc(rpt_unc), .win_vld(win_vld), .win_idx(win_idx), .win_unc(win_unc)
   );

   // event counters, index 0 correctable, index 1 uncorrectable
   logic [INC_W-1:0] inc_v [2];
   logic [CNT_W-1:0] cnt_v [2];
   logic [1:0]       rd_v;

   assign rd_v = {cnt_rd_unc, cnt_rd_corr};

   always_comb begin
      inc_v[0] = '0;
      inc_v[1] = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (hit[i] && !rpt_unc[i]) inc_v[0] = inc_v[0] + INC_W'(1);
         if (hit[i] &&  rpt_unc[i]) inc_v[1] = inc_v[1] + INC_W'(1);
      end
   end

   generate
      for (genvar c = 0; c < 2; c++) begin : g_cnt
         edc_evt_cnt #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .rd(rd_v[c]), .inc(inc_v[c]), .cnt_o(cnt_v[c])
         );
      end
   endgenerate

   assign cnt_corr = cnt_v[0];
   assign cnt_unc  = cnt_v[1];

   // single captured record
   logic [NUM_SRC-1:0] src_q, src_nx, kept;
   logic               unc_q, unc_nx, ram_q, ram_nx, take;
   logic [CAP_W-1:0]   addr_q, addr_nx;
   logic [WAY_W-1:0]   way_q, way_nx;
   logic [BIT_W-1:0]   bit_q, bit_nx;
   int unsigned        sel;

   always_comb begin
      sel     = int'(win_idx);
      kept    = src_q & ~(cmd_we ? cmd_clr : '0);
      take    = win_vld && ((kept == '0) || (!unc_q && win_unc));
      src_nx  = kept;
      unc_nx  = unc_q;
      ram_nx  = ram_q;
      addr_nx = addr_q;
      way_nx  = way_q;
      bit_nx  = bit_q;
      if (kept == '0) begin
         unc_nx  = 1'b0;
         ram_nx  = 1'b0;
         addr_nx = '0;
         way_nx  = '0;
         bit_nx  = '0;
      end
      if (take) begin
         src_nx  = NUM_SRC'(1) << sel;
         unc_nx  = win_unc;
         ram_nx  = rpt_ram[sel];
         addr_nx = rpt_addr[sel*ADDR_W + CAP_LSB +: CAP_W];
         way_nx  = rpt_ram[sel] ? '0 : rpt_way[sel*WAY_W +: WAY_W];
         bit_nx  = rpt_bit[sel*BIT_W +: BIT_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q  <= '0;
         unc_q  <= 1'b0;
         ram_q  <= 1'b0;
         addr_q <= '0;
         way_q  <= '0;
         bit_q  <= '0;
      end else begin
         src_q  <= src_nx;
         unc_q  <= unc_nx;
         ram_q  <= ram_nx;
         addr_q <= addr_nx;
         way_q  <= way_nx;
         bit_q  <= bit_nx;
      end
   end

   assign rec_src  = src_q;
   assign rec_unc  = unc_q;
   assign rec_addr = addr_q;
   assign rec_way  = way_q;
   assign rec_ram  = ram_q;
   assign rec_bit  = bit_q;
   assign exc_corr = (src_q != '0) && !unc_q;
   assign exc_unc  = (src_q != '0) &&  unc_q;
endmodule

// File: rtl/edc_err_capture_chk.sv
module edc_err_capture_chk #(
   parameter int unsigned NUM_SRC = 3,
   parameter int unsigned CAP_W   = 27,
   parameter int unsigned WAY_W   = 2,
   parameter int unsigned CNT_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_we,
   input logic               cmd_on,
   input logic               cmd_off,
   input logic               cmd_hold,
   input logic [NUM_SRC-1:0] cmd_clr,
   input logic               cnt_rd_corr,
   input logic               cnt_rd_unc,
   input logic [1:0]         mode_o,
   input logic [NUM_SRC-1:0] rec_src,
   input logic               rec_unc,
   input logic [CAP_W-1:0]   rec_addr,
   input logic [WAY_W-1:0]   rec_way,
   input logic               rec_ram,
   input logic               exc_corr,
   input logic               exc_unc,
   input logic [CNT_W-1:0]   cnt_corr,
   input logic [CNT_W-1:0]   cnt_unc
);
   logic hit_clr;
   assign hit_clr = cmd_we && ((cmd_clr & rec_src) != '0);

   a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o != 2'd3);

   a_r2_multi_cmd_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && ($countones({cmd_on, cmd_off, cmd_hold}) > 1)) |=> (mode_o == 2'd0));

   a_r4_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'd1 && !cnt_rd_corr) |=> $stable(cnt_corr));

   a_r5_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rec_src));

   a_r5_ram_way_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rec_ram |-> (rec_way == '0));

   a_r6_corr_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_corr && !hit_clr) |=> (exc_unc || (exc_corr && $stable(rec_addr))));

   a_r7_unc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_unc && !hit_clr) |=> (exc_unc && $stable(rec_addr)));

   a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_src == '0) |-> (rec_addr == '0 && !rec_unc && !rec_ram));

   a_r10_exc_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(exc_corr && exc_unc));

   a_r12_corr_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_corr == {CNT_W{1'b1}} && !cnt_rd_corr) |=> (cnt_corr == {CNT_W{1'b1}}));

   a_r12_unc_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_unc == {CNT_W{1'b1}} && !cnt_rd_unc) |=> (cnt_unc == {CNT_W{1'b1}}));

   a_r13_read_small: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rd_unc |=> (cnt_unc <= CNT_W'(NUM_SRC)));
endmodule

bind edc_err_capture edc_err_capture_chk #(
   .NUM_SRC(NUM_SRC), .CAP_W(CAP_W), .WAY_W(WAY_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_on(cmd_on), .cmd_off(cmd_off),
   .cmd_hold(cmd_hold), .cmd_clr(cmd_clr), .cnt_rd_corr(cnt_rd_corr),
   .cnt_rd_unc(cnt_rd_unc), .mode_o(mode_o), .rec_src(rec_src), .rec_unc(rec_unc),
   .rec_addr(rec_addr), .rec_way(rec_way), .rec_ram(rec_ram), .exc_corr(exc_corr),
   .exc_unc(exc_unc), .cnt_corr(cnt_corr), .cnt_unc(cnt_unc)
);

// File: tb/edc_err_capture_bench.sv
module edc_err_capture_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_we, cmd_on, cmd_off, cmd_hold;
   logic [2:0]  cmd_clr;
   logic [1:0]  pen_we;
   logic [31:0] pen_wdata;
   logic [31:0] probe_addr;
   logic        probe_chk;
   logic [1:0]  mode_o;
   logic [2:0]  rpt_vld, rpt_unc, rpt_ram;
   logic [31:0] b_addr [3];
   logic [1:0]  b_way  [3];
   logic [7:0]  b_bit  [3];
   logic [95:0] rpt_addr;
   logic [5:0]  rpt_way;
   logic [23:0] rpt_bit;
   logic        cnt_rd_corr, cnt_rd_unc;
   logic [2:0]  rec_src;
   logic        rec_unc, rec_ram, exc_corr, exc_unc;
   logic [26:0] rec_addr;
   logic [1:0]  rec_way;
   logic [7:0]  rec_bit, cnt_corr, cnt_unc;

   assign rpt_addr = {b_addr[2], b_addr[1], b_addr[0]};
   assign rpt_way  = {b_way[2], b_way[1], b_way[0]};
   assign rpt_bit  = {b_bit[2], b_bit[1], b_bit[0]};

   always #5 clk = ~clk;

   edc_err_capture u_edc_err_capture (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_on(cmd_on), .cmd_off(cmd_off),
      .cmd_hold(cmd_hold), .cmd_clr(cmd_clr), .pen_we(pen_we), .pen_wdata(pen_wdata),
      .probe_addr(probe_addr), .probe_chk(probe_chk), .mode_o(mode_o),
      .rpt_vld(rpt_vld), .rpt_unc(rpt_unc), .rpt_addr(rpt_addr), .rpt_way(rpt_way),
      .rpt_ram(rpt_ram), .rpt_bit(rpt_bit), .cnt_rd_corr(cnt_rd_corr),
      .cnt_rd_unc(cnt_rd_unc), .rec_src(rec_src), .rec_unc(rec_unc),
      .rec_addr(rec_addr), .rec_way(rec_way), .rec_ram(rec_ram), .rec_bit(rec_bit),
      .exc_corr(exc_corr), .exc_unc(exc_unc), .cnt_corr(cnt_corr), .cnt_unc(cnt_unc)
   );

   // bench model of the requirements
   logic [1:0]  m_mode;
   logic [63:0] m_pen;
   logic [2:0]  m_src;
   logic        m_unc, m_ram;
   logic [26:0] m_addr;
   logic [1:0]  m_way;
   logic [7:0]  m_bit;
   int          m_cc, m_cu;
   int          total = 0, bad = 0;
   bit          done = 1'b0;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      cmd_we = 0; cmd_on = 0; cmd_off = 0; cmd_hold = 0; cmd_clr = 0;
      pen_we = 0; pen_wdata = 0; cnt_rd_corr = 0; cnt_rd_unc = 0;
      rpt_vld = 0; rpt_unc = 0; rpt_ram = 0;
      for (int i = 0; i < 3; i++) begin
         b_addr[i] = 0; b_way[i] = 0; b_bit[i] = 0;
      end
   endtask

   task automatic rep(int i, bit unc, logic [31:0] a, bit ram, logic [1:0] w, logic [7:0] bp);
      rpt_vld[i] = 1'b1; rpt_unc[i] = unc; rpt_ram[i] = ram;
      b_addr[i] = a; b_way[i] = w; b_bit[i] = bp;
   endtask

   function automatic int sat(int v);
      return (v > 255) ? 255 : v;
   endfunction

   task automatic compare_all();
      chk("R1", "mode", 64'(mode_o), 64'(m_mode));
      chk("R3", "probe", 64'(probe_chk), 64'(m_mode == 2'd1 && m_pen[probe_addr[20:15]]));
      chk("R5", "rec_src", 64'(rec_src), 64'(m_src));
      chk("R5", "rec_unc", 64'(rec_unc), 64'(m_unc));
      chk("R5", "rec_addr", 64'(rec_addr), 64'(m_addr));
      chk("R5", "rec_way", 64'(rec_way), 64'(m_way));
      chk("R5", "rec_ram", 64'(rec_ram), 64'(m_ram));
      chk("R5", "rec_bit", 64'(rec_bit), 64'(m_bit));
      chk("R10", "exc_corr", 64'(exc_corr), 64'(m_src != 0 && !m_unc));
      chk("R10", "exc_unc", 64'(exc_unc), 64'(m_src != 0 && m_unc));
      chk("R11", "cnt_corr", 64'(cnt_corr), 64'(m_cc));
      chk("R11", "cnt_unc", 64'(cnt_unc), 64'(m_cu));
   endtask

   task automatic cycle();
      logic [1:0]  n_mode = m_mode;
      logic [63:0] n_pen = m_pen;
      logic [2:0]  hit, kept, n_src;
      logic        n_unc, n_ram, wunc;
      logic [26:0] n_addr;
      logic [1:0]  n_way;
      logic [7:0]  n_bit;
      int nc = 0, nu = 0, w = -1, n_cc, n_cu;
      if (cmd_we) begin
         if (int'(cmd_on) + int'(cmd_off) + int'(cmd_hold) > 1) n_mode = 2'd0;
         else if (cmd_on)   n_mode = 2'd1;
         else if (cmd_off)  n_mode = 2'd0;
         else if (cmd_hold) n_mode = 2'd2;
      end
      if (pen_we[0]) n_pen[31:0]  = pen_wdata;
      if (pen_we[1]) n_pen[63:32] = pen_wdata;
      for (int i = 0; i < 3; i++) begin
         hit[i] = rpt_vld[i] && (m_mode == 2'd1) && m_pen[b_addr[i][20:15]];
         if (hit[i] && rpt_unc[i]) nu++;
         if (hit[i] && !rpt_unc[i]) nc++;
      end
      n_cc = sat((cnt_rd_corr ? 0 : m_cc) + nc);
      n_cu = sat((cnt_rd_unc ? 0 : m_cu) + nu);
      kept = m_src & (cmd_we ? ~cmd_clr : 3'b111);
      n_src = kept; n_unc = m_unc; n_ram = m_ram; n_addr = m_addr; n_way = m_way; n_bit = m_bit;
      if (kept == 0) begin
         n_unc = 0; n_ram = 0; n_addr = 0; n_way = 0; n_bit = 0;
      end
      wunc = 1'b0;
      for (int i = 0; i < 3; i++) if (w < 0 && hit[i] && rpt_unc[i]) begin w = i; wunc = 1'b1; end
      for (int i = 0; i < 3; i++) if (w < 0 && hit[i]) w = i;
      if (w >= 0 && (kept == 0 || (!m_unc && wunc))) begin
         n_src = 3'b001 << w; n_unc = wunc; n_ram = rpt_ram[w];
         n_addr = b_addr[w][31:5]; n_way = rpt_ram[w] ? 2'd0 : b_way[w]; n_bit = b_bit[w];
      end
      @(posedge clk);
      #1;
      m_mode = n_mode; m_pen = n_pen; m_src = n_src; m_unc = n_unc; m_ram = n_ram;
      m_addr = n_addr; m_way = n_way; m_bit = n_bit; m_cc = n_cc; m_cu = n_cu;
      compare_all();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      idle();
      probe_addr = 0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      m_mode = 0; m_pen = 0; m_src = 0; m_unc = 0; m_ram = 0;
      m_addr = 0; m_way = 0; m_bit = 0; m_cc = 0; m_cu = 0;
      compare_all();                                   // R1 R3 reset state

      // R3: enable all pages
      pen_we = 2'b11; pen_wdata = 32'hFFFF_FFFF; cycle(); idle();
      // R4: report while mode is off is ignored
      rep(0, 1'b0, 32'h0000_8A60, 1'b0, 2'd1, 8'd3); cycle(); idle();
      chk("R4", "off mode record", 64'(rec_src), 64'd0);
      chk("R4", "off mode count", 64'(cnt_corr), 64'd0);
      // R1: switch on
      cmd_we = 1; cmd_on = 1; cycle(); idle();
      chk("R1", "mode on", 64'(mode_o), 64'd1);
      // R3/R4: page 0 off
      pen_we = 2'b01; pen_wdata = 32'hFFFF_FFFE; cycle(); idle();
      probe_addr = 32'h0000_0040; #1;
      chk("R3", "probe page0", 64'(probe_chk), 64'd0);
      probe_addr = 32'h0000_8000; #1;
      chk("R3", "probe page1", 64'(probe_chk), 64'd1);
      rep(0, 1'b1, 32'h0000_0040, 1'b1, 2'd0, 8'd9); cycle(); idle();
      chk("R4", "disabled page record", 64'(rec_src), 64'd0);
      chk("R4", "disabled page count", 64'(cnt_unc), 64'd0);
      // R8: data corr, program unc, dma unc together
      rep(0, 1'b0, 32'h0000_8000, 1'b0, 2'd2, 8'd1);
      rep(1, 1'b1, 32'h0001_0020, 1'b0, 2'd3, 8'd77);
      rep(2, 1'b1, 32'h0001_8000, 1'b1, 2'd1, 8'd5);
      cycle(); idle();
      chk("R8", "winner source", 64'(rec_src), 64'b010);
      chk("R8", "winner addr", 64'(rec_addr), 64'h801);
      chk("R11", "simultaneous corr", 64'(cnt_corr), 64'd1);
      chk("R11", "simultaneous unc", 64'(cnt_unc), 64'd2);
      // R9: clear program record
      cmd_we = 1; cmd_clr = 3'b010; cycle(); idle();
      chk("R9", "cleared", 64'(rec_src), 64'd0);
      chk("R9", "cleared addr", 64'(rec_addr), 64'd0);
      // R6/R7
      rep(2, 1'b0, 32'h0000_8100, 1'b0, 2'd1, 8'd2); cycle(); idle();
      rep(0, 1'b0, 32'h0000_9000, 1'b0, 2'd1, 8'd4); cycle(); idle();
      chk("R6", "corr held", 64'(rec_src), 64'b100);
      rep(1, 1'b1, 32'h0000_A000, 1'b0, 2'd2, 8'd6); cycle(); idle();
      chk("R7", "unc overwrites", 64'(rec_src), 64'b010);
      chk("R7", "exc_unc", 64'(exc_unc), 64'd1);
      rep(0, 1'b1, 32'h0000_B000, 1'b0, 2'd2, 8'd8); cycle(); idle();
      chk("R6", "unc held", 64'(rec_addr), 64'(32'h0000_A000 >> 5));
      // R9: wrong clear ignored; clear with new report captures it
      cmd_we = 1; cmd_clr = 3'b001; cycle(); idle();
      chk("R9", "other clear no effect", 64'(rec_src), 64'b010);
      cmd_we = 1; cmd_clr = 3'b010; rep(0, 1'b0, 32'h0000_C040, 1'b0, 2'd3, 8'd11); cycle(); idle();
      chk("R9", "clear plus capture", 64'(rec_src), 64'b001);
      // R5: RAM forces way 0
      cmd_we = 1; cmd_clr = 3'b111; cycle(); idle();
      rep(1, 1'b0, 32'hFFFF_FFE0, 1'b1, 2'd3, 8'd200); cycle(); idle();
      chk("R5", "ram way", 64'(rec_way), 64'd0);
      chk("R5", "ram flag", 64'(rec_ram), 64'd1);
      chk("R5", "addr top", 64'(rec_addr), 64'h7FF_FFFF);
      // R2 and hold mode
      cmd_we = 1; cmd_on = 1; cmd_hold = 1; cycle(); idle();
      chk("R2", "multi command", 64'(mode_o), 64'd0);
      cmd_we = 1; cmd_hold = 1; cycle(); idle();
      chk("R1", "hold", 64'(mode_o), 64'd2);
      cnt_rd_corr = 1; cnt_rd_unc = 1; cycle(); idle();
      rep(2, 1'b1, 32'h0000_8000, 1'b0, 2'd0, 8'd1); cycle(); idle();
      chk("R4", "hold ignores", 64'(cnt_unc), 64'd0);
      cmd_we = 1; cmd_on = 1; cycle(); idle();
      // R12 saturation
      for (int k = 0; k < 90; k++) begin
         for (int i = 0; i < 3; i++) rep(i, 1'b0, 32'h0000_8000 + 32'(i * 32), 1'b0, 2'd0, 8'(k));
         cycle();
      end
      idle();
      chk("R12", "saturated", 64'(cnt_corr), 64'd255);
      // R13 read with event
      cnt_rd_corr = 1; rep(1, 1'b0, 32'h0000_8000, 1'b0, 2'd0, 8'd0); cycle(); idle();
      chk("R13", "read plus event", 64'(cnt_corr), 64'd1);
      cnt_rd_corr = 1; cycle(); idle();
      chk("R13", "read alone", 64'(cnt_corr), 64'd0);

      // constrained random phase
      for (int n = 0; n < 4000; n++) begin
         idle();
         if ($urandom % 16 == 0) begin
            cmd_we = 1;
            if ($urandom % 10 < 7) cmd_on = 1;
            else begin cmd_on = 1'($urandom); cmd_off = 1'($urandom); cmd_hold = 1'($urandom); end
            cmd_clr = 3'($urandom);
         end
         if ($urandom % 40 == 0) begin
            pen_we = 2'($urandom);
            pen_wdata = ($urandom % 4 == 0) ? $urandom : 32'hFFFF_FFFF;
         end
         for (int i = 0; i < 3; i++) begin
            if ($urandom % 4 == 0)
               rep(i, ($urandom % 3 == 0), $urandom, 1'($urandom), 2'($urandom), 8'($urandom));
         end
         cnt_rd_corr = ($urandom % 20 == 0);
         cnt_rd_unc  = ($urandom % 20 == 0);
         probe_addr  = $urandom;
         cycle();
      end
      idle();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule